// File: doc/BRIEF.md
# Extended-Data-Out Page-Mode DRAM Device Model

This block is a synthesizable behavioural model of a small asynchronous DRAM with a 16-bit data path split into two byte lanes. A fast system clock samples the active-low strobes (row strobe, one column strobe per lane, write enable, output enable) and a multiplexed address, and the model acts on the edges it sees. The row address is taken when the row strobe falls. The column address is taken on the first column-strobe fall after both column strobes have been high. Each lane then performs a read or a write into a 16 x 16 array of words.

Writes are classified per lane. In an early write, write enable is already low when the lane's column strobe falls. In a late write or read-modify-write, write enable falls while the column strobe is low. A late write attempted with output enable low is suppressed and becomes a read. Read data stays on the bus after the column strobe rises, which is the extended-data-out hold. If one lane does an early write and the other a late write within one column cycle, the model raises an error flag. The tri-state bus is modelled as a data-in vector, a data-out vector and a per-lane drive enable.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, both lane drive enables are 0, `mode_err` is 0 and `lane_kind` is all zeros.
- R2: The row is taken from `addr` when `ras_n` falls. The column is taken when a lane's `cas_n` falls while both `cas_n` bits had been high. Reads return the word stored at that row and column, including successive column cycles within one row cycle (page mode).
- R3: If `we_n` is low when a lane's `cas_n` falls, that lane writes the `din` byte present at that fall (early write). The lane's drive enable stays 0 whatever `oe_n` is, and its kind code becomes 2.
- R4: If `we_n` falls while a reading lane's `cas_n` is low and `oe_n` is high, that lane writes the `din` byte present at the fall of `we_n` (late write). Its kind code becomes 3.
- R5: If `we_n` falls while a reading lane's `cas_n` is low and `oe_n` is low, the array is not written. The lane keeps driving the read data, and its kind code becomes 4.
- R6: `cas_n[0]` controls lane 0, which is `dout`/`din` bits 7:0, and `cas_n[1]` controls bits 15:8. A lane whose `cas_n` stays high is neither written nor driven.
- R7: After a read, a lane keeps driving valid data once its `cas_n` rises, for as long as `ras_n` and `oe_n` stay low and `we_n` stays high.
- R8: The hold of R7 ends, and the drive enable drops to 0, when `oe_n` rises, when `we_n` falls, or when `ras_n` rises with `cas_n` high.
- R9: While `ras_n` and a reading lane's `cas_n` are low, `oe_n` low drives the data and `oe_n` high turns the lane off, repeatedly.
- R10: An early write on one lane and a late write on the other within one column cycle set `mode_err`. It stays set until the next fall of `ras_n`.
- R11: After both `cas_n` bits have been high (precharge), a lane may use a different write mode from the previous column cycle without setting `mode_err`.
- R12: `lane_kind` holds 3 bits per lane, with lane 0 in bits 2:0. The codes are 0 idle, 1 read, 2 early write, 3 late write and 4 suppressed write. Every code returns to 0 once both `cas_n` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Column strobe per byte lane, active low, bit 0 = lower lane |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Multiplexed row/column address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-lane bus drive enable |
| mode_err | output | 1 | Mixed early/late write in one column cycle |
| lane_kind | output | 6 | Per-lane access kind code |

## Verification
The bench builds the model with its default parameters: 4-bit row and column addresses, two 8-bit lanes, and therefore a 256-word array. This size lets every word be written by an early write with an arithmetic pattern and then read back with the extended-data-out hold checked on each one. Targeted sequences then cover the cases around that sweep: byte-lane masking, late and suppressed writes, output-enable toggling, each hold-ending event, and mixed-mode errors with and without precharge.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        K_IDLE  = 3'd0,
        K_READ  = 3'd1,
        K_EARLY = 3'd2,
        K_LATE  = 3'd3,
        K_BLOCK = 3'd4
    } lane_kind_e;

    typedef struct packed {
        logic ras;
        logic we;
        logic oe;
    } ctl_t;

    localparam ctl_t CTL_INACTIVE = '{ras: 1'b1, we: 1'b1, oe: 1'b1};

    function automatic logic is_early(input lane_kind_e k);
        return k == K_EARLY;
    endfunction

    function automatic logic is_late(input lane_kind_e k);
        return k == K_LATE;
    endfunction

endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler import edo_pkg::*; #(
    parameter int LANES = 2,
    parameter int AW    = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output ctl_t             s_ctl,
    output logic [LANES-1:0] s_cas,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_din,
    output logic             ras_f,
    output logic             we_f,
    output logic             oe_r,
    output logic [LANES-1:0] cas_f,
    output logic             prev_cas_idle
);

    ctl_t             p_ctl;
    logic [LANES-1:0] p_cas;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_ctl  <= CTL_INACTIVE;
            p_ctl  <= CTL_INACTIVE;
            s_cas  <= '1;
            p_cas  <= '1;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_ctl  <= '{ras: ras_n, we: we_n, oe: oe_n};
            p_ctl  <= s_ctl;
            s_cas  <= cas_n;
            p_cas  <= s_cas;
            s_addr <= addr;
            s_din  <= din;
        end
    end

    assign ras_f         = p_ctl.ras & ~s_ctl.ras;
    assign we_f          = p_ctl.we & ~s_ctl.we;
    assign oe_r          = ~p_ctl.oe & s_ctl.oe;
    assign cas_f         = p_cas & ~s_cas;
    assign prev_cas_idle = &p_cas;

endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl import edo_pkg::*; #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cas_f,
    input  logic              s_cas,
    input  logic              s_ras,
    input  logic              s_we,
    input  logic              we_f,
    input  logic              s_oe,
    input  logic              oe_r,
    input  logic              precharge,
    input  logic [LANE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic              early_ev,
    output logic              late_ev,
    output lane_kind_e        kind,
    output logic              drive,
    output logic [LANE_W-1:0] dout
);

    logic hold;
    logic we_in_cycle;

    assign we_in_cycle = we_f && !s_cas && (kind == K_READ);
    assign early_ev    = cas_f && !s_we;
    assign late_ev     = we_in_cycle && s_oe;
    assign wr_en       = early_ev || late_ev;
    assign drive       = hold && !s_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= K_IDLE;
            hold <= 1'b0;
            dout <= '0;
        end else if (cas_f) begin
            if (!s_we) begin
                kind <= K_EARLY;
                hold <= 1'b0;
            end else begin
                kind <= K_READ;
                hold <= 1'b1;
                dout <= rd_byte;
            end
        end else if (we_in_cycle) begin
            if (s_oe) begin
                kind <= K_LATE;
                hold <= 1'b0;
            end else begin
                kind <= K_BLOCK;
            end
        end else begin
            if (precharge)
                kind <= K_IDLE;
            if (s_cas && (oe_r || !s_we || s_ras))
                hold <= 1'b0;
        end
    end

    a_r3_early_never_drives: assert property (@(posedge clk) disable iff (rst)
        (kind == K_EARLY) |-> !drive);

    a_r5_blocked_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BLOCK && !s_cas && !s_oe) |-> drive);

    a_r8_hold_ends_on_we: assert property (@(posedge clk) disable iff (rst)
        (s_cas && we_f && !cas_f) |=> !drive);

endmodule

// File: rtl/edo_mem_array.sv
module edo_mem_array #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int IDX_W = ROW_W + COL_W,
    localparam int DEPTH = 1 << IDX_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en[l])
                mem[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model import edo_pkg::*; #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int DW    = LANES * LANE_W,
    localparam int IDX_W = ROW_W + COL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ras_n,
    input  logic [LANES-1:0]   cas_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      din,
    output logic [DW-1:0]      dout,
    output logic [LANES-1:0]   dq_oe,
    output logic               mode_err,
    output logic [3*LANES-1:0] lane_kind
);

    ctl_t             s_ctl;
    logic [LANES-1:0] s_cas;
    logic [AW-1:0]    s_addr;
    logic [DW-1:0]    s_din;
    logic             ras_f, we_f, oe_r, prev_cas_idle;
    logic [LANES-1:0] cas_f_raw, cas_f;

    edo_pin_sampler #(.LANES(LANES), .AW(AW), .DW(DW)) u_samp (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .s_ctl(s_ctl), .s_cas(s_cas),
        .s_addr(s_addr), .s_din(s_din), .ras_f(ras_f), .we_f(we_f),
        .oe_r(oe_r), .cas_f(cas_f_raw), .prev_cas_idle(prev_cas_idle)
    );

    // column strobes only count inside a row cycle
    assign cas_f = cas_f_raw & {LANES{~s_ctl.ras}};

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             col_first;
    logic [COL_W-1:0] eff_col;
    logic             precharge;

    assign precharge = &s_cas;
    assign col_first = (|cas_f) && prev_cas_idle;
    assign eff_col   = col_first ? s_addr[COL_W-1:0] : col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_f)
                row_q <= s_addr[ROW_W-1:0];
            if (col_first)
                col_q <= s_addr[COL_W-1:0];
        end
    end

    logic [IDX_W-1:0] idx;
    logic [LANES-1:0] wr_en, early_ev, late_ev;
    logic [DW-1:0]    rd_data;
    lane_kind_e       kind [LANES];

    assign idx = {row_q, eff_col};

    edo_mem_array #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rd_idx(idx), .wr_idx(idx), .wr_en(wr_en),
        .wr_data(s_din), .rd_data(rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctrl #(.LANE_W(LANE_W)) u_lane (
            .clk(clk), .rst(rst), .cas_f(cas_f[g]), .s_cas(s_cas[g]),
            .s_ras(s_ctl.ras), .s_we(s_ctl.we), .we_f(we_f), .s_oe(s_ctl.oe),
            .oe_r(oe_r), .precharge(precharge),
            .rd_byte(rd_data[g*LANE_W +: LANE_W]),
            .wr_en(wr_en[g]), .early_ev(early_ev[g]), .late_ev(late_ev[g]),
            .kind(kind[g]), .drive(dq_oe[g]), .dout(dout[g*LANE_W +: LANE_W])
        );
        assign lane_kind[3*g +: 3] = kind[g];

        a_r6_no_write_cas_high: assert property (@(posedge clk) disable iff (rst)
            wr_en[g] |-> !s_cas[g]);

        a_r12_write_marks_kind: assert property (@(posedge clk) disable iff (rst)
            wr_en[g] |=> (kind[g] == K_EARLY || kind[g] == K_LATE));
    end

    logic any_e, any_l, mixed;

    always_comb begin
        any_e = |early_ev;
        any_l = |late_ev;
        for (int l = 0; l < LANES; l++) begin
            any_e = any_e | is_early(kind[l]);
            any_l = any_l | is_late(kind[l]);
        end
        mixed = (|early_ev || |late_ev) && any_e && any_l;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_err <= 1'b0;
        else if (ras_f)
            mode_err <= 1'b0;
        else if (mixed)
            mode_err <= 1'b1;
    end

    a_r10_err_clears_on_row: assert property (@(posedge clk) disable iff (rst)
        $fell(s_ctl.ras) |=> !mode_err);

    a_r2_row_stable: assert property (@(posedge clk) disable iff (rst)
        (!s_ctl.ras && $past(!s_ctl.ras) && $past(!s_ctl.ras, 2)) |-> $stable(row_q));

endmodule

// File: tb/edo_dram_model_tb.sv
module edo_dram_model_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        ras_n, we_n, oe_n;
    logic [1:0]  cas_n;
    logic [3:0]  addr;
    logic [15:0] din;
    logic [15:0] dout;
    logic [1:0]  dq_oe;
    logic        mode_err;
    logic [5:0]  lane_kind;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    edo_dram_model u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
        .mode_err(mode_err), .lane_kind(lane_kind)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int r, input int c);
        return {4'(r), 4'(c), 4'(r ^ c), 4'(r + c + 3)};
    endfunction

    task automatic step();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic early_wr(input int r, input int c, input logic [1:0] lanes,
                            input logic [15:0] data);
        addr = 4'(r); ras_n = 1'b0; step();
        addr = 4'(c); we_n = 1'b0; oe_n = 1'b0; din = data; cas_n = ~lanes; step();
        chk("R3 early write keeps bus off", {30'd0, dq_oe}, 32'd0);
        cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; step();
        ras_n = 1'b1; step();
    endtask

    task automatic rd_word(input int r, input int c, input logic [15:0] exp,
                           input string req);
        addr = 4'(r); ras_n = 1'b0; step();
        addr = 4'(c); oe_n = 1'b0; cas_n = 2'b00; step();
        chk(req, {14'd0, dq_oe, dout}, {14'd0, 2'b11, exp});
        cas_n = 2'b11; step();
        chk("R7 hold after cas rise", {14'd0, dq_oe, dout}, {14'd0, 2'b11, exp});
        oe_n = 1'b1; step();
        ras_n = 1'b1; step();
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ras_n = 1'b1; cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; din = '0;
        repeat (4) @(posedge clk);
        #1; rst = 1'b0; step();
        chk("R1 reset drive", {30'd0, dq_oe}, 32'd0);
        chk("R1 reset err", {31'd0, mode_err}, 32'd0);
        chk("R12 reset kind", {26'd0, lane_kind}, 32'd0);

        // R2/R3 sweep: early-write and read back every word
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                early_wr(r, c, 2'b11, pat(r, c));
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                rd_word(r, c, pat(r, c), "R2 sweep read");

        // R6 lower lane only
        addr = 4'd1; ras_n = 1'b0; step();
        addr = 4'd2; we_n = 1'b0; din = 16'hA5C3; cas_n = 2'b10; step();
        chk("R6 byte kind", {26'd0, lane_kind}, {26'd0, 3'd0, 3'd2});
        cas_n = 2'b11; we_n = 1'b1; step(); ras_n = 1'b1; step();
        rd_word(1, 2, {pat(1, 2)[15:8], 8'hC3}, "R6 upper lane untouched");

        // R4 late write on both lanes
        addr = 4'd3; ras_n = 1'b0; step();
        addr = 4'd4; cas_n = 2'b00; step();
        chk("R12 read kind", {26'd0, lane_kind}, {26'd0, 3'd1, 3'd1});
        din = 16'h1234; we_n = 1'b0; step();
        chk("R4 late kind", {26'd0, lane_kind}, {26'd0, 3'd3, 3'd3});
        chk("R4 late bus off", {30'd0, dq_oe}, 32'd0);
        cas_n = 2'b11; we_n = 1'b1; step();
        chk("R12 precharge clears kind", {26'd0, lane_kind}, 32'd0);
        ras_n = 1'b1; step();
        rd_word(3, 4, 16'h1234, "R4 late data stored");

        // R5 suppressed late write
        addr = 4'd5; ras_n = 1'b0; step();
        addr = 4'd6; oe_n = 1'b0; cas_n = 2'b00; step();
        din = 16'hFFFF; we_n = 1'b0; step();
        chk("R5 blocked kind", {26'd0, lane_kind}, {26'd0, 3'd4, 3'd4});
        chk("R5 blocked drives read", {14'd0, dq_oe, dout}, {14'd0, 2'b11, pat(5, 6)});
        cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; step(); ras_n = 1'b1; step();
        rd_word(5, 6, pat(5, 6), "R5 array unchanged");

        // R9 OE toggling, then R8 end by ras rise
        addr = 4'd7; ras_n = 1'b0; step();
        addr = 4'd8; oe_n = 1'b0; cas_n = 2'b00; step();
        chk("R9 oe low drives", {30'd0, dq_oe}, 32'd3);
        oe_n = 1'b1; step();
        chk("R9 oe high off", {30'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; step();
        chk("R9 oe low again", {14'd0, dq_oe, dout}, {14'd0, 2'b11, pat(7, 8)});
        cas_n = 2'b11; step();
        chk("R7 hold valid", {30'd0, dq_oe}, 32'd3);
        ras_n = 1'b1; step();
        chk("R8 ras rise ends hold", {30'd0, dq_oe}, 32'd0);
        oe_n = 1'b1; step();

        // R8 end by we fall
        addr = 4'd9; ras_n = 1'b0; step();
        addr = 4'd1; oe_n = 1'b0; cas_n = 2'b00; step();
        cas_n = 2'b11; step();
        chk("R7 hold before we", {30'd0, dq_oe}, 32'd3);
        we_n = 1'b0; step();
        chk("R8 we fall ends hold", {30'd0, dq_oe}, 32'd0);
        we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step();

        // R8 end by oe rise
        addr = 4'd10; ras_n = 1'b0; step();
        addr = 4'd2; oe_n = 1'b0; cas_n = 2'b00; step();
        cas_n = 2'b11; step();
        oe_n = 1'b1; step();
        oe_n = 1'b0; step();
        chk("R8 oe rise ends hold", {30'd0, dq_oe}, 32'd0);
        oe_n = 1'b1; ras_n = 1'b1; step();

        // R2 page mode: two columns in one row cycle
        addr = 4'd6; ras_n = 1'b0; step();
        addr = 4'd1; oe_n = 1'b0; cas_n = 2'b00; step();
        chk("R2 page first col", {16'd0, dout}, {16'd0, pat(6, 1)});
        cas_n = 2'b11; step();
        addr = 4'd2; cas_n = 2'b00; step();
        chk("R2 page second col", {16'd0, dout}, {16'd0, pat(6, 2)});
        cas_n = 2'b11; oe_n = 1'b1; step(); ras_n = 1'b1; step();

        // R10 mixed modes in one column cycle
        addr = 4'd2; ras_n = 1'b0; step();
        addr = 4'd3; cas_n = 2'b10; step();
        din = 16'h5A5A; we_n = 1'b0; step();
        cas_n = 2'b00; step();
        chk("R10 mixed raises err", {31'd0, mode_err}, 32'd1);
        chk("R12 mixed kinds", {26'd0, lane_kind}, {26'd0, 3'd2, 3'd3});
        cas_n = 2'b11; we_n = 1'b1; step();
        chk("R10 err held", {31'd0, mode_err}, 32'd1);
        ras_n = 1'b1; step();
        chk("R10 err held ras high", {31'd0, mode_err}, 32'd1);
        addr = 4'd0; ras_n = 1'b0; step();
        chk("R10 err cleared", {31'd0, mode_err}, 32'd0);
        ras_n = 1'b1; step();

        // R11 mode change after precharge
        addr = 4'd4; ras_n = 1'b0; step();
        addr = 4'd5; din = 16'h00EE; we_n = 1'b0; cas_n = 2'b10; step();
        cas_n = 2'b11; we_n = 1'b1; step();
        cas_n = 2'b01; step();
        din = 16'hDD00; we_n = 1'b0; step();
        chk("R11 no err after precharge", {31'd0, mode_err}, 32'd0);
        chk("R11 kinds", {26'd0, lane_kind}, {26'd0, 3'd3, 3'd0});
        cas_n = 2'b11; we_n = 1'b1; step(); ras_n = 1'b1; step();
        rd_word(4, 5, 16'hDDEE, "R11 both modes stored");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule